// File: doc/BRIEF.md
# Priority Time-Shared Character Channel Controller

This block lets twelve peripheral channels move single characters to and from core memory on their own while the processor keeps running. A channel asks for service by holding its request line high. Between transfers the controller picks the requesting channel with the highest priority. The console is channel 0 and has the highest priority. The paper tape punch is channel 11 and has the lowest. The controller then reads that channel's transfer pointer from a small 32-word by 16-bit pointer memory, performs one memory access, writes the incremented pointer back and pulses the channel's acknowledge line.

Each channel owns a pointer word, which gives the current core address and the direction of transfer. It also owns a control word, which names one of up to eight mechanisms linked to the channel. The processor loads these words through a simple write port and reads any word back through a read port. It can also ask any channel for its condition: whether it is requesting and whether it is in service. A stall input from the core memory arbiter holds a transfer in place until the memory accepts it.

Top module: `chan_xfer_ctrl`

## Requirements
- R1: After reset, every acknowledge line and the memory request are low, and all 32 pointer-memory words read back as zero.
- R2: When several channels request at the same time, the lowest-numbered one is served first. Channel 0 (console) is always preferred and channel 11 (punch) is always served last.
- R3: Requests are sampled only while no transfer is in progress. A request raised during a transfer, even one of higher priority, waits for that transfer to finish. Only one memory access is outstanding at any time.
- R4: The pointer word of channel c sits at pointer-memory index c. Bit 15 gives the direction (1 = device to memory, which writes core; 0 = memory to device, which reads core) and bits 14:0 give the core address. Channel c's control word sits at index c+16, and its bits 2:0 hold the mechanism number.
- R5: A device-to-memory transfer writes the channel's character (input slice c of `dev_wchar`) into core at the pointer address.
- R6: A memory-to-device transfer presents the character read from core at the pointer address on `dev_rchar` while the acknowledge is high. Read data comes back on `mem_rdata` one cycle after the memory accepts the access.
- R7: After each character the address field of the pointer word goes up by one and wraps from 0x7FFF to 0. The direction bit is kept.
- R8: Each transfer raises exactly one acknowledge bit, that of the served channel, for exactly one clock. With no stall, the acknowledge is visible 3 clocks after the request is sampled for a write to core, and 4 clocks after for a read from core.
- R9: While `mem_stall` is high, the memory request stays asserted with address, write enable and write data unchanged. Each stalled clock delays the acknowledge by one cycle.
- R10: The processor write port updates the addressed pointer-memory word on the next clock, and the read port returns any word combinationally. If the processor writes the pointer word that the controller is writing back in the same clock, the controller's value is kept.
- R11: `cpu_cond` for the channel selected by `cpu_cond_sel` reads bit 1 = request line high and bit 0 = that channel is being served. A selection of 12 or more reads zero.
- R12: While the acknowledge is high, `dev_mech` carries the mechanism number from the served channel's control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req | input | 12 | Per-channel service request, bit 0 = console |
| chan_ack | output | 12 | One-clock acknowledge to the served channel |
| dev_wchar | input | 96 | Characters offered by the channels, slice c = bits 8c+7:8c |
| dev_rchar | output | 8 | Character read from core, valid with the acknowledge |
| dev_mech | output | 3 | Mechanism number of the served channel, valid with the acknowledge |
| mem_req | output | 1 | Core memory access request |
| mem_we | output | 1 | 1 = write core, 0 = read core |
| mem_addr | output | 15 | Core character address |
| mem_wdata | output | 8 | Character written to core |
| mem_rdata | input | 8 | Character read from core, one cycle after acceptance |
| mem_stall | input | 1 | Core busy; the access is not accepted this clock |
| cpu_wr_en | input | 1 | Processor write strobe for the pointer memory |
| cpu_wr_addr | input | 5 | Pointer-memory word to write |
| cpu_wr_data | input | 16 | Value to write |
| cpu_rd_addr | input | 5 | Pointer-memory word to read |
| cpu_rd_data | output | 16 | Value of the word addressed by cpu_rd_addr |
| cpu_cond_sel | input | 4 | Channel whose condition is read |
| cpu_cond | output | 2 | {requesting, in service} of the selected channel |

## Verification
Every channel is served on its own, twice in a row, with a direction that alternates between channels. This separates index errors in the pointer and control words, mistakes in the direction encoding, and a missing or doubled increment, and it checks the latency of reads and writes separately. Every pair of channels then requests together, and all twelve request at once, which exposes any break in the fixed priority order. Further single patterns cover the address wrap at 0x7FFF, a multi-cycle stall, a higher-priority request that arrives during a transfer, a processor write that collides with the writeback, and the condition readout while the selected channel is waiting, in service and idle.

// File: rtl/chx_pkg.sv
package chx_pkg;

    localparam int CHX_NUM_CH    = 12;
    localparam int CHX_PTR_WORDS = 32;
    localparam int CHX_CTRL_BASE = 16;
    localparam int CHX_ADDR_W    = 15;
    localparam int CHX_CHAR_W    = 8;
    localparam int CHX_MECH_W    = 3;
    localparam int CHX_PTR_W     = CHX_ADDR_W + 1;

    // Pointer word: direction on top, core address below.
    typedef struct packed {
        logic                  to_mem;   // 1: device -> core (write)
        logic [CHX_ADDR_W-1:0] addr;
    } chx_ptr_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_XFER  = 3'd2,
        ST_CAPT  = 3'd3,
        ST_DONE  = 3'd4
    } chx_state_e;

    function automatic chx_ptr_t chx_ptr_step(chx_ptr_t p);
        chx_ptr_t r;
        r      = p;
        r.addr = p.addr + CHX_ADDR_W'(1);
        return r;
    endfunction

endpackage

// File: rtl/chx_prio_arb.sv
module chx_prio_arb #(
    parameter int N     = 12,
    localparam int IW   = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);

    logic [N:0]   blocked;
    logic [N-1:0] win;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign win[i]       = req[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | req[i];
    end

    logic unused_tail;
    assign unused_tail = blocked[N];

    assign valid = |req;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (win[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/chx_ptr_mem.sv
module chx_ptr_mem #(
    parameter int WORDS = 32,
    parameter int W     = 16,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [W-1:0]  eng_wdata,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [W-1:0]  cpu_wdata,
    input  logic [AW-1:0] pa_addr,
    output logic [W-1:0]  pa_data,
    input  logic [AW-1:0] pb_addr,
    output logic [W-1:0]  pb_data,
    input  logic [AW-1:0] pc_addr,
    output logic [W-1:0]  pc_data
);

    logic [W-1:0] words [WORDS];

    // Engine writeback takes precedence over a processor write to the same word.
    always_ff @(posedge clk) begin
        for (int w = 0; w < WORDS; w++) begin
            if (rst) begin
                words[w] <= '0;
            end else if (eng_we && eng_addr == AW'(w)) begin
                words[w] <= eng_wdata;
            end else if (cpu_we && cpu_addr == AW'(w)) begin
                words[w] <= cpu_wdata;
            end
        end
    end

    assign pa_data = words[pa_addr];
    assign pb_data = words[pb_addr];
    assign pc_data = words[pc_addr];

endmodule

// File: rtl/chx_seq.sv
module chx_seq
    import chx_pkg::*;
#(
    parameter int N_CH      = 12,
    parameter int PTR_WORDS = 32,
    parameter int CTRL_BASE = 16,
    localparam int IDX_W    = $clog2(N_CH),
    localparam int PTR_AW   = $clog2(PTR_WORDS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       arb_valid,
    input  logic [IDX_W-1:0]           arb_idx,
    output logic                       grant_fire,
    output logic                       busy,
    output logic [IDX_W-1:0]           cur_idx,
    output logic [PTR_AW-1:0]          ptr_raddr,
    input  logic [CHX_PTR_W-1:0]       ptr_rdata,
    output logic [PTR_AW-1:0]          ctrl_raddr,
    input  logic [CHX_PTR_W-1:0]       ctrl_rdata,
    output logic                       wb_en,
    output logic [PTR_AW-1:0]          wb_addr,
    output logic [CHX_PTR_W-1:0]       wb_data,
    input  logic [N_CH*CHX_CHAR_W-1:0] dev_wchar,
    output logic [N_CH-1:0]            chan_ack,
    output logic [CHX_CHAR_W-1:0]      dev_rchar,
    output logic [CHX_MECH_W-1:0]      dev_mech,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [CHX_ADDR_W-1:0]      mem_addr,
    output logic [CHX_CHAR_W-1:0]      mem_wdata,
    input  logic [CHX_CHAR_W-1:0]      mem_rdata,
    input  logic                       mem_stall
);

    chx_state_e            state;
    logic [IDX_W-1:0]      cur;
    chx_ptr_t              ptr_q;
    logic [CHX_MECH_W-1:0] mech_q;
    logic [CHX_CHAR_W-1:0] wchar_q;
    logic [CHX_CHAR_W-1:0] rchar_q;

    logic [CHX_CHAR_W-1:0] wchar_arr [N_CH];
    for (genvar i = 0; i < N_CH; i++) begin : g_slice
        assign wchar_arr[i] = dev_wchar[i*CHX_CHAR_W +: CHX_CHAR_W];
    end

    logic unused_ctrl;
    assign unused_ctrl = ^ctrl_rdata[CHX_PTR_W-1:CHX_MECH_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cur     <= '0;
            ptr_q   <= '0;
            mech_q  <= '0;
            wchar_q <= '0;
            rchar_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (arb_valid) begin
                        cur   <= arb_idx;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    ptr_q   <= chx_ptr_t'(ptr_rdata);
                    mech_q  <= ctrl_rdata[CHX_MECH_W-1:0];
                    wchar_q <= wchar_arr[cur];
                    state   <= ST_XFER;
                end
                ST_XFER: begin
                    if (!mem_stall) state <= ptr_q.to_mem ? ST_DONE : ST_CAPT;
                end
                ST_CAPT: begin
                    rchar_q <= mem_rdata;
                    state   <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign grant_fire = (state == ST_IDLE) && arb_valid;
    assign busy       = (state != ST_IDLE);
    assign cur_idx    = cur;

    assign ptr_raddr  = PTR_AW'(cur);
    assign ctrl_raddr = PTR_AW'(cur) + PTR_AW'(CTRL_BASE);

    assign wb_en   = (state == ST_DONE);
    assign wb_addr = PTR_AW'(cur);
    assign wb_data = chx_ptr_step(ptr_q);

    assign mem_req   = (state == ST_XFER);
    assign mem_we    = ptr_q.to_mem;
    assign mem_addr  = ptr_q.addr;
    assign mem_wdata = wchar_q;

    for (genvar i = 0; i < N_CH; i++) begin : g_ack
        assign chan_ack[i] = (state == ST_DONE) && (cur == IDX_W'(i));
    end

    assign dev_rchar = rchar_q;
    assign dev_mech  = mech_q;

endmodule

// File: rtl/chan_xfer_ctrl.sv
module chan_xfer_ctrl
    import chx_pkg::*;
#(
    parameter int N_CH      = CHX_NUM_CH,
    parameter int PTR_WORDS = CHX_PTR_WORDS,
    parameter int CTRL_BASE = CHX_CTRL_BASE,
    localparam int IDX_W    = $clog2(N_CH),
    localparam int PTR_AW   = $clog2(PTR_WORDS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_CH-1:0]            chan_req,
    output logic [N_CH-1:0]            chan_ack,
    input  logic [N_CH*CHX_CHAR_W-1:0] dev_wchar,
    output logic [CHX_CHAR_W-1:0]      dev_rchar,
    output logic [CHX_MECH_W-1:0]      dev_mech,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [CHX_ADDR_W-1:0]      mem_addr,
    output logic [CHX_CHAR_W-1:0]      mem_wdata,
    input  logic [CHX_CHAR_W-1:0]      mem_rdata,
    input  logic                       mem_stall,
    input  logic                       cpu_wr_en,
    input  logic [PTR_AW-1:0]          cpu_wr_addr,
    input  logic [CHX_PTR_W-1:0]       cpu_wr_data,
    input  logic [PTR_AW-1:0]          cpu_rd_addr,
    output logic [CHX_PTR_W-1:0]       cpu_rd_data,
    input  logic [IDX_W-1:0]           cpu_cond_sel,
    output logic [1:0]                 cpu_cond
);

    logic                 arb_valid;
    logic [IDX_W-1:0]     arb_idx;
    logic                 grant_fire;
    logic [IDX_W-1:0]     grant_idx;
    logic                 busy;
    logic [IDX_W-1:0]     cur_idx;
    logic [PTR_AW-1:0]    ptr_raddr;
    logic [PTR_AW-1:0]    ctrl_raddr;
    logic [CHX_PTR_W-1:0] ptr_rdata;
    logic [CHX_PTR_W-1:0] ctrl_rdata;
    logic                 wb_en;
    logic [PTR_AW-1:0]    wb_addr;
    logic [CHX_PTR_W-1:0] wb_data;

    chx_prio_arb #(.N(N_CH)) u_arb (
        .req   (chan_req),
        .valid (arb_valid),
        .idx   (arb_idx)
    );

    assign grant_idx = arb_idx;

    chx_ptr_mem #(.WORDS(PTR_WORDS), .W(CHX_PTR_W)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .eng_we    (wb_en),
        .eng_addr  (wb_addr),
        .eng_wdata (wb_data),
        .cpu_we    (cpu_wr_en),
        .cpu_addr  (cpu_wr_addr),
        .cpu_wdata (cpu_wr_data),
        .pa_addr   (ptr_raddr),
        .pa_data   (ptr_rdata),
        .pb_addr   (ctrl_raddr),
        .pb_data   (ctrl_rdata),
        .pc_addr   (cpu_rd_addr),
        .pc_data   (cpu_rd_data)
    );

    chx_seq #(.N_CH(N_CH), .PTR_WORDS(PTR_WORDS), .CTRL_BASE(CTRL_BASE)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .arb_valid  (arb_valid),
        .arb_idx    (arb_idx),
        .grant_fire (grant_fire),
        .busy       (busy),
        .cur_idx    (cur_idx),
        .ptr_raddr  (ptr_raddr),
        .ptr_rdata  (ptr_rdata),
        .ctrl_raddr (ctrl_raddr),
        .ctrl_rdata (ctrl_rdata),
        .wb_en      (wb_en),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data),
        .dev_wchar  (dev_wchar),
        .chan_ack   (chan_ack),
        .dev_rchar  (dev_rchar),
        .dev_mech   (dev_mech),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_stall  (mem_stall)
    );

    // Condition readout: {request line, in service}.
    always_comb begin
        cpu_cond = 2'b00;
        for (int i = 0; i < N_CH; i++) begin
            if (cpu_cond_sel == IDX_W'(i)) begin
                cpu_cond = {chan_req[i], busy && (cur_idx == IDX_W'(i))};
            end
        end
    end

endmodule

// File: rtl/chx_ctrl_chk.sv
module chx_ctrl_chk #(
    parameter int N_CH   = 12,
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 15,
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [N_CH-1:0]   chan_req,
    input logic [N_CH-1:0]   chan_ack,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_stall,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CHAR_W-1:0] mem_wdata,
    input logic              grant_fire,
    input logic [IDX_W-1:0]  grant_idx
);

    logic [N_CH-1:0] above;
    always_comb begin
        for (int i = 0; i < N_CH; i++) above[i] = (IDX_W'(i) < grant_idx);
    end

    p_grant_top_r2: assert property (@(posedge clk) disable iff (rst)
        grant_fire |-> (chan_req[grant_idx] && ((chan_req & above) == '0)));

    p_grant_gap_r3: assert property (@(posedge clk) disable iff (rst)
        grant_fire |=> !grant_fire);

    p_req_ack_excl_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (chan_ack == '0));

    p_ack_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_ack));

    p_ack_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (|chan_ack) |=> (chan_ack == '0));

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_stall) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

bind chan_xfer_ctrl chx_ctrl_chk #(
    .N_CH   (N_CH),
    .IDX_W  (IDX_W),
    .ADDR_W (chx_pkg::CHX_ADDR_W),
    .CHAR_W (chx_pkg::CHX_CHAR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .chan_req   (chan_req),
    .chan_ack   (chan_ack),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_stall  (mem_stall),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .grant_fire (grant_fire),
    .grant_idx  (grant_idx)
);

// File: tb/sim_chan_xfer_ctrl.sv
module sim_chan_xfer_ctrl;

    localparam int NCH = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NCH-1:0]   chan_req = '0;
    logic [NCH-1:0]   chan_ack;
    logic [7:0]       wch [NCH];
    logic [NCH*8-1:0] dev_wchar;
    logic [7:0]       dev_rchar;
    logic [2:0]       dev_mech;
    logic             mem_req, mem_we;
    logic [14:0]      mem_addr;
    logic [7:0]       mem_wdata;
    logic [7:0]       mem_rdata = '0;
    logic             mem_stall = 1'b0;
    logic             cpu_wr_en = 1'b0;
    logic [4:0]       cpu_wr_addr = '0;
    logic [15:0]      cpu_wr_data = '0;
    logic [4:0]       cpu_rd_addr = '0;
    logic [15:0]      cpu_rd_data;
    logic [3:0]       cpu_cond_sel = '0;
    logic [1:0]       cpu_cond;

    always_comb begin
        for (int i = 0; i < NCH; i++) dev_wchar[i*8 +: 8] = wch[i];
    end

    chan_xfer_ctrl u0 (
        .clk(clk), .rst(rst), .chan_req(chan_req), .chan_ack(chan_ack),
        .dev_wchar(dev_wchar), .dev_rchar(dev_rchar), .dev_mech(dev_mech),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_stall(mem_stall),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
        .cpu_rd_addr(cpu_rd_addr), .cpu_rd_data(cpu_rd_data),
        .cpu_cond_sel(cpu_cond_sel), .cpu_cond(cpu_cond)
    );

    // Core memory model: accepted read returns data one clock later.
    logic [7:0] bmem [32768];

    function automatic logic [7:0] init_char(int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    always @(posedge clk) begin
        if (mem_req && !mem_stall) begin
            if (mem_we) bmem[mem_addr] <= mem_wdata;
            else        mem_rdata      <= bmem[mem_addr];
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk_eq(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_word(int w, logic [15:0] v);
        @(negedge clk);
        cpu_wr_en   = 1'b1;
        cpu_wr_addr = 5'(w);
        cpu_wr_data = v;
        @(negedge clk);
        cpu_wr_en   = 1'b0;
    endtask

    task automatic rd_word(int w, output logic [15:0] v);
        @(negedge clk);
        cpu_rd_addr = 5'(w);
        #1;
        v = cpu_rd_data;
    endtask

    task automatic wait_ack(output logic [NCH-1:0] ack, output int lat,
                            output logic [7:0] rch, output logic [2:0] mch);
        lat = 0;
        ack = '0;
        rch = '0;
        mch = '0;
        while (lat < 60) begin
            @(negedge clk);
            lat++;
            if (|chan_ack) begin
                ack = chan_ack;
                rch = dev_rchar;
                mch = dev_mech;
                break;
            end
        end
    endtask

    task automatic serve(int c, output logic [NCH-1:0] ack, output int lat,
                         output logic [7:0] rch, output logic [2:0] mch);
        @(negedge clk);
        chan_req[c] = 1'b1;
        wait_ack(ack, lat, rch, mch);
        chan_req[c] = 1'b0;
    endtask

    initial begin
        logic [NCH-1:0] ack;
        int             lat;
        logic [7:0]     rch;
        logic [2:0]     mch;
        logic [15:0]    v;
        bit             wr;
        logic [14:0]    base;
        logic [2:0]     mc;

        for (int a = 0; a < 32768; a++) bmem[a] = init_char(a);
        for (int i = 0; i < NCH; i++) wch[i] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk_eq("R1 ack after reset", 32'(chan_ack), 0);
        chk_eq("R1 mem_req after reset", 32'(mem_req), 0);
        for (int w = 0; w < 32; w++) begin
            rd_word(w, v);
            chk_eq("R1 pointer word cleared", 32'(v), 0);
        end

        // R10: plain processor write and read back
        set_word(5, 16'hABCD);
        rd_word(5, v);
        chk_eq("R10 cpu write readback", 32'(v), 32'hABCD);

        // R4 R5 R6 R7 R8 R12: every channel, alternating direction, two characters each
        for (int c = 0; c < NCH; c++) begin
            wr   = c[0];
            base = 15'(1000 * c + 37);
            mc   = 3'((3 * c + 1) % 8);
            set_word(c, {wr, base});
            set_word(16 + c, {13'd0, mc});
            for (int k = 0; k < 2; k++) begin
                wch[c] = 8'(8'h40 + c + 16 * k);
                serve(c, ack, lat, rch, mch);
                chk_eq("R8 ack latency", 32'(lat), wr ? 3 : 4);
                chk_eq("R8 ack targets served channel", 32'(ack), 32'(1) << c);
                chk_eq("R12 mechanism number", 32'(mch), 32'(mc));
                if (wr)
                    chk_eq("R5 character written to core", 32'(bmem[base + 15'(k)]),
                           32'(8'h40 + c + 16 * k));
                else
                    chk_eq("R6 character read from core", 32'(rch),
                           32'(init_char(int'(base) + k)));
                rd_word(c, v);
                chk_eq("R7 pointer advanced", 32'(v), 32'({wr, 15'(base + 15'(k) + 15'd1)}));
            end
        end

        // R7: address wrap keeps direction
        set_word(3, 16'hFFFF);
        wch[3] = 8'h2C;
        serve(3, ack, lat, rch, mch);
        chk_eq("R5 write at top address", 32'(bmem[32767]), 32'h2C);
        rd_word(3, v);
        chk_eq("R7 wrap to zero", 32'(v), 32'h8000);

        // R2: every pair of channels requesting together
        for (int c = 0; c < NCH; c++) set_word(c, {1'b1, 15'(20000 + c * 300)});
        for (int i = 0; i < NCH; i++) begin
            for (int j = i + 1; j < NCH; j++) begin
                @(negedge clk);
                chan_req[i] = 1'b1;
                chan_req[j] = 1'b1;
                wait_ack(ack, lat, rch, mch);
                chk_eq("R2 higher priority first", 32'(ack), 32'(1) << i);
                chan_req = chan_req & ~ack;
                wait_ack(ack, lat, rch, mch);
                chk_eq("R2 lower priority second", 32'(ack), 32'(1) << j);
                chan_req = '0;
            end
        end

        // R2: all channels at once, console down to punch
        @(negedge clk);
        chan_req = '1;
        for (int k = 0; k < NCH; k++) begin
            wait_ack(ack, lat, rch, mch);
            chk_eq("R2 full order", 32'(ack), 32'(1) << k);
            chan_req = chan_req & ~ack;
        end
        chan_req = '0;

        // R3: higher-priority request during a transfer waits
        @(negedge clk);
        chan_req[7] = 1'b1;
        @(negedge clk);
        chan_req[0] = 1'b1;
        wait_ack(ack, lat, rch, mch);
        chk_eq("R3 no preemption", 32'(ack), 32'(1) << 7);
        chan_req = chan_req & ~ack;
        wait_ack(ack, lat, rch, mch);
        chk_eq("R3 waiting channel served next", 32'(ack), 32'(1));
        chan_req = '0;

        // R11: condition readout
        @(negedge clk);
        cpu_cond_sel = 4'd6;
        chan_req[1]  = 1'b1;
        chan_req[6]  = 1'b1;
        #1;
        chk_eq("R11 requesting not served", 32'(cpu_cond), 32'b10);
        @(negedge clk);
        #1;
        chk_eq("R11 waiting behind other channel", 32'(cpu_cond), 32'b10);
        cpu_cond_sel = 4'd1;
        #1;
        chk_eq("R11 in service", 32'(cpu_cond), 32'b11);
        cpu_cond_sel = 4'd6;
        wait_ack(ack, lat, rch, mch);
        chan_req[1] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk_eq("R11 second channel in service", 32'(cpu_cond), 32'b11);
        wait_ack(ack, lat, rch, mch);
        chan_req[6] = 1'b0;
        @(negedge clk);
        #1;
        chk_eq("R11 idle channel", 32'(cpu_cond), 32'b00);
        cpu_cond_sel = 4'd13;
        chan_req[11] = 1'b0;
        #1;
        chk_eq("R11 out of range selection", 32'(cpu_cond), 32'b00);

        // R9: stall holds the access
        set_word(2, {1'b1, 15'd500});
        wch[2] = 8'h77;
        @(negedge clk);
        mem_stall   = 1'b1;
        chan_req[2] = 1'b1;
        lat = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (k >= 2 && k <= 5) begin
                chk_eq("R9 request held in stall", 32'(mem_req), 1);
                chk_eq("R9 address held in stall", 32'(mem_addr), 500);
            end
            if (k == 5) mem_stall = 1'b0;
            if (|chan_ack) begin
                lat = k;
                break;
            end
        end
        chan_req[2] = 1'b0;
        chk_eq("R9 ack delayed by stall", 32'(lat), 6);
        chk_eq("R9 write after stall", 32'(bmem[500]), 32'h77);
        rd_word(2, v);
        chk_eq("R9 pointer after stall", 32'(v), 32'h81F5);

        // R10: writeback wins over a colliding processor write
        set_word(4, {1'b1, 15'd200});
        @(negedge clk);
        chan_req[4] = 1'b1;
        wait_ack(ack, lat, rch, mch);
        chan_req[4] = 1'b0;
        cpu_wr_en   = 1'b1;
        cpu_wr_addr = 5'd4;
        cpu_wr_data = 16'h1234;
        @(negedge clk);
        cpu_wr_en   = 1'b0;
        rd_word(4, v);
        chk_eq("R10 writeback wins collision", 32'(v), 32'h80C9);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule